// File: doc/BRIEF.md
# Tick-Driven Watchdog Counter

This block is a small watchdog built around a down counter. The counter steps down once for each tick pulse that arrives from a separate time-slot unit. After a hardware reset the watchdog sits idle and ignores ticks. The first software write of a non-zero value arms it and loads that value as the starting count. Once it is armed, only a hardware reset can stop it.

The block raises a trap output in two cases. The first is when the count runs down to zero. The second is when software writes the counter more than once inside one tick interval, which shows the supervising code is looping instead of reloading at its normal pace. A global count-enable gates the ticks. While that enable is low the watchdog is frozen. The tick generator is not part of this block.

Software is expected to reload the counter once per tick interval with a non-zero value. A write of zero does not reload the counter, but it still counts as a write when the block looks for double writes. The trap stays high until the next hardware reset.

Top module: `wdt_tick_watchdog`

## Requirements
- R1: After reset `trap` is 0 and the watchdog is idle: any number of enabled ticks with no prior write leave `trap` at 0.
- R2: A write of a non-zero value N to an idle watchdog arms it and loads N. After exactly N enabled ticks `trap` reads 1, and after N-1 such ticks it still reads 0. This holds for every N from 1 to 2^CNT_W-1.
- R3: While armed, a non-zero write loads the new value, and the count restarts from that value. Writes of zero never disarm the watchdog.
- R4: Once `trap` is 1 it stays 1 until `rst_n` is asserted, whatever is written or ticked.
- R5: A write that arrives while an earlier write has already been seen in the current tick interval sets `trap` on the following cycle. A write, then an enabled tick, then a write does not trap.
- R6: A write in the same cycle as an enabled tick belongs to the new interval. A non-zero write in that cycle loads its value with no decrement in that cycle. A further write before the next enabled tick traps.
- R7: A write of zero does not load the counter and does not arm an idle watchdog, but it counts as a write for the double-write check of R5.
- R8: While `cnt_en` is 0, tick pulses have no effect. They neither decrement the count nor close the current write interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Single-cycle software write strobe |
| wr_data | input | CNT_W | Value written to the counter |
| tick | input | 1 | Single-cycle pulse from the time-slot unit |
| cnt_en | input | 1 | Global counter enable; gates `tick` |
| trap | output | 1 | Sticky watchdog trap |

## Verification
The assertions assume that `tick` and `wr_en` are single-cycle strobes sampled at the clock edge. They also assume that `wr_data` matters only in a cycle where `wr_en` is high. The bench drives every strobe for exactly one clock, changing it on the falling edge. It resets between scenarios so that each one starts from the idle state. The expected trap cycle is worked out by counting enabled ticks against the value loaded.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // A write reloads the counter only when its value is non-zero.
  function automatic logic wdt_is_reload(input logic wr, input logic [7:0] val);
    return wr && (val != 8'd0);
  endfunction

  // Next counter value: a load has priority over a decrement, and a decrement stops at zero.
  function automatic logic [7:0] wdt_next_count(input logic [7:0] cur,
                                                input logic       load,
                                                input logic [7:0] val,
                                                input logic       dec);
    logic [7:0] nxt;
    nxt = cur;
    if (load)                      nxt = val;
    else if (dec && cur != 8'd0)   nxt = cur - 8'd1;
    return nxt;
  endfunction

  // A decrement that leaves the count at zero is an expiry.
  function automatic logic wdt_hits_zero(input logic [7:0] cur, input logic dec);
    return dec && (cur == 8'd1);
  endfunction

endpackage

// File: rtl/wdt_arm_ctl.sv
module wdt_arm_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic armed
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    armed_q <= 1'b0;
    else if (load) armed_q <= 1'b1;
  end

  assign armed = armed_q;

  // R3: only reset can disarm.
  assert_armed_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

  // R7: without a load the watchdog cannot become armed.
  assert_arm_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !load) |=> !armed_q);
endmodule

// File: rtl/wdt_interval_mon.sv
module wdt_interval_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic tick_eff,
  output logic wr_seen,
  output logic dbl_wr
);
  logic seen_q;

  // A write that lands with a tick opens the new interval as already written.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= 1'b0;
    else if (tick_eff) seen_q <= wr_en;
    else if (wr_en)    seen_q <= 1'b1;
  end

  assign wr_seen = seen_q;
  assign dbl_wr  = wr_en && seen_q && !tick_eff;

  // R6: a write that shares a cycle with a tick marks the new interval.
  assert_tick_write_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_eff && wr_en) |=> seen_q);

  // R5: a tick with no write starts a clean interval.
  assert_tick_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_eff && !wr_en) |=> !seen_q);

  // R8: no tick and no write leave the flag alone.
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_eff && !wr_en) |=> $stable(seen_q));
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick_eff,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             dec;

  assign dec    = armed && tick_eff && !load;
  assign expire = wdt_hits_zero(cnt_q, dec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= wdt_next_count(cnt_q, load, load_val, dec);
  end

  assign count = cnt_q;

  // R2: an idle counter does not move without a load.
  assert_idle_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> $stable(cnt_q));

  // R8: with no tick passed through, the count only changes on a load.
  assert_no_tick_no_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_eff && !load) |=> $stable(cnt_q));

  // R3: a load puts the written value in the counter.
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R2: an expiry leaves the count at zero.
  assert_expire_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_tick_watchdog.sv
module wdt_tick_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  input  logic             cnt_en,
  output logic             trap
);
  logic             tick_eff;
  logic             load;
  logic             armed;
  logic             wr_seen;
  logic             dbl_wr;
  logic             expire;
  logic [CNT_W-1:0] count;
  logic             trap_q;

  assign tick_eff = tick && cnt_en;
  assign load     = wr_en && (wr_data != '0);

  wdt_arm_ctl u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .armed (armed)
  );

  wdt_interval_mon u_ivl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .tick_eff (tick_eff),
    .wr_seen  (wr_seen),
    .dbl_wr   (dbl_wr)
  );

  wdt_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .load     (load),
    .load_val (wr_data),
    .tick_eff (tick_eff),
    .count    (count),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  trap_q <= 1'b0;
    else if (expire || dbl_wr)   trap_q <= 1'b1;
  end

  assign trap = trap_q;

  // R4: the trap is sticky.
  assert_trap_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |=> trap_q);

  // R5: a second write inside an interval raises the trap.
  assert_double_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_seen && !tick_eff) |=> trap_q);

  // R2: an expiry raises the trap.
  assert_expire_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> trap_q);

  // R1: an idle watchdog with a clean interval cannot trap on its own.
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !wr_en && !trap_q) |=> !trap_q);
endmodule

// File: tb/wdt_tick_watchdog_tb.sv
module wdt_tick_watchdog_tb;
  localparam int CNT_W = 8;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             tick = 1'b0;
  logic             cnt_en = 1'b1;
  logic             trap;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  wdt_tick_watchdog #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .cnt_en(cnt_en), .trap(trap)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: trap=%b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0; cnt_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Each strobe lasts one clock and is driven on the falling edge.
  task automatic strobe(input logic w, input logic [CNT_W-1:0] d, input logic t);
    wr_en = w; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [CNT_W-1:0] d);  strobe(1'b1, d, 1'b0); endtask
  task automatic tk();                           strobe(1'b0, '0, 1'b1); endtask
  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) tk();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung, cycles=%0d expected < 200000", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state, then no trap on ticks alone.
    do_reset();
    check("R1 reset", trap, 1'b0);
    ticks(300);
    check("R1 idle ticks", trap, 1'b0);

    // R2: sweep every load value.
    for (int n = 1; n <= MAXV; n++) begin
      do_reset();
      wr(n[CNT_W-1:0]);
      ticks(n - 1);
      check("R2 before expiry", trap, 1'b0);
      tk();
      check("R2 at expiry", trap, 1'b1);
    end

    // R4: sticky through writes and ticks.
    do_reset();
    wr(8'd1); tk();
    wr(8'd50); tk(); wr(8'd9); ticks(3);
    check("R4 sticky", trap, 1'b1);
    do_reset();
    check("R4 cleared by reset", trap, 1'b0);

    // R3: reload restarts count.
    do_reset();
    wr(8'd3); ticks(2); wr(8'd6); ticks(5);
    check("R3 reload no early trap", trap, 1'b0);
    tk();
    check("R3 reload trap", trap, 1'b1);

    // R5: double write traps; write/tick/write does not.
    do_reset();
    wr(8'd20); tk(); wr(8'd20);
    check("R5 spaced writes", trap, 1'b0);
    wr(8'd20);
    check("R5 double write", trap, 1'b1);

    // R6: write with tick opens new interval, loads without decrement.
    do_reset();
    wr(8'd5); tk();
    strobe(1'b1, 8'd3, 1'b1);
    check("R6 combined no trap", trap, 1'b0);
    ticks(2);
    check("R6 load no decrement", trap, 1'b0);
    tk();
    check("R6 expiry from new value", trap, 1'b1);
    do_reset();
    wr(8'd5); tk();
    strobe(1'b1, 8'd7, 1'b1);
    wr(8'd7);
    check("R6 write after combined", trap, 1'b1);

    // R7: zero write when idle does not arm.
    do_reset();
    wr(8'd0); ticks(300);
    check("R7 zero idle", trap, 1'b0);
    wr(8'd2); ticks(2);
    check("R7 arm after zero", trap, 1'b1);
    // R7: zero write when armed does not reload.
    do_reset();
    wr(8'd4); ticks(2); wr(8'd0); tk();
    check("R7 zero armed no early", trap, 1'b0);
    tk();
    check("R7 zero armed expiry kept", trap, 1'b1);
    // R7: zero write counts for double write.
    do_reset();
    wr(8'd0); wr(8'd9);
    check("R7 zero counts as write", trap, 1'b1);

    // R8: disabled ticks do nothing.
    do_reset();
    wr(8'd3);
    cnt_en = 1'b0; ticks(5); cnt_en = 1'b1;
    ticks(2);
    check("R8 disabled ticks ignored", trap, 1'b0);
    tk();
    check("R8 expiry after enable", trap, 1'b1);
    do_reset();
    wr(8'd3);
    cnt_en = 1'b0; tk(); cnt_en = 1'b1;
    wr(8'd4);
    check("R8 disabled tick keeps interval", trap, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule